// File: doc/BRIEF.md
# Character-Fetch Bus-Steal Arbiter

This block decides, cycle by cycle, whether the processor may use the shared bus during a raster line on which the video engine must fetch character data. On such a line the video side needs 40 consecutive bus cycles. It warns the processor a few cycles early by driving a bus-available-low signal. During that warning period the processor keeps running only for as long as its cycles are writes. The first read cycle freezes it. It then stays frozen until the fetch burst ends.

The processor's bus direction is not a pin. The block works it out from a description of the current instruction: a class code, the instruction length and, for ordinary instructions, the number of trailing write cycles. It then counts its own position inside the instruction. That count freezes while the processor is held. At the end of each stolen burst the block reports how many cycles it actually held the processor. The result lies between 40 and 43, depending on how many writes fell into the warning period.

Top module: `badline_steal_arb`

## Requirements
- R1: While and right after reset, ba_n is 1, rdy is 1, stall_len is 0 and stall_done is 0.
- R2: With badline high, ba_n is 0 exactly for raster cycles 12 to 54 inclusive, with defaults. That span is 3 lead cycles plus 40 fetch cycles starting at cycle 15. It is 1 on every other cycle.
- R3: With badline low, ba_n stays 1 and rdy stays 1 for the whole line, and no stall_done pulse appears.
- R4: During the lead cycles, a cycle decoded as a write keeps rdy at 1, provided every earlier cycle of the warning period was also a write.
- R5: The first read cycle while ba_n is 0 drives rdy to 0 in that same cycle. rdy then stays 0 until ba_n returns to 1.
- R6: Class code 0 (break/interrupt sequence) writes on instruction cycles 3, 4 and 5 and reads on all others.
- R7: Class code 1 (subroutine call) writes on instruction cycles 4 and 5 and reads on all others.
- R8: Class code 2 writes on its last op_nwr cycles of op_len. Any cycle beyond op_len, without a new op_start, is a read. op_start marks instruction cycle 1.
- R9: In the cycle after the last fetch cycle, stall_done pulses for one cycle. stall_len then holds the number of cycles rdy was 0 in that burst, which is 43 minus the writes completed in the lead.
- R10: rdy is 1 whenever ba_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| raster_cycle | input | 6 | Cycle index within the raster line, 0 to 62 |
| badline | input | 1 | Current line needs a character fetch burst |
| op_start | input | 1 | This cycle is cycle 1 of a new instruction |
| op_class | input | 2 | 0 break/interrupt, 1 subroutine call, 2 other |
| op_len | input | 3 | Instruction length in cycles (class 2) |
| op_nwr | input | 2 | Trailing write cycles (class 2), 0 to 3 |
| ba_n | output | 1 | Bus-available, active low |
| rdy | output | 1 | Processor may complete this cycle |
| stall_len | output | 6 | Cycles held in the last burst |
| stall_done | output | 1 | One-cycle strobe: stall_len updated |

## Verification
On every cycle, the embedded properties check four things. rdy never drops while the bus is available. A hold, once begun, lasts until release. The warning window opens on the correct raster cycle. The burst report appears only right after release and never exceeds 43. Only the bench scenarios can show the per-class write positions. They place a break sequence, a subroutine call and plain instructions at chosen offsets against the warning window. Each placement leads to a specific charged length of 40, 41, 42 or 43, and the bench predicts that length independently.

// File: rtl/bl_pkg.sv
package bl_pkg;

    typedef enum logic [1:0] {
        OPC_TRAP  = 2'd0,
        OPC_CALL  = 2'd1,
        OPC_PLAIN = 2'd2,
        OPC_RSVD  = 2'd3
    } op_class_e;

    typedef struct packed {
        op_class_e  cls;
        logic [2:0] len;
        logic [1:0] nwr;
    } op_desc_t;

    localparam int ICYC_W = 4;
    localparam logic [ICYC_W-1:0] ICYC_MAX = '1;

    // Bus direction of one instruction cycle (1-based index); 1 means write.
    function automatic logic is_write_cycle(op_desc_t d, logic [ICYC_W-1:0] cyc);
        logic w;
        unique case (d.cls)
            OPC_TRAP: w = (cyc >= 4'd3) && (cyc <= 4'd5);
            OPC_CALL: w = (cyc >= 4'd4) && (cyc <= 4'd5);
            default:  w = (cyc <= {1'b0, d.len}) &&
                          (({1'b0, cyc} + {3'b000, d.nwr}) > {2'b00, d.len});
        endcase
        return w;
    endfunction

    function automatic logic [ICYC_W-1:0] sat_inc(logic [ICYC_W-1:0] v);
        return (v == ICYC_MAX) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/bl_window.sv
module bl_window #(
    parameter int LINE_CYCLES = 63,
    parameter int FETCH_FIRST = 15,
    parameter int FETCH_CNT   = 40,
    parameter int LEAD        = 3
) (
    input  logic [$clog2(LINE_CYCLES)-1:0] raster_cycle,
    input  logic                           badline,
    output logic                           steal,
    output logic                           win_last
);
    localparam int CYC_W     = $clog2(LINE_CYCLES);
    localparam int WIN_START = FETCH_FIRST - LEAD;
    localparam int WIN_END   = FETCH_FIRST + FETCH_CNT - 1;

    logic in_win;

    always_comb begin
        in_win   = (raster_cycle >= CYC_W'(WIN_START)) &&
                   (raster_cycle <= CYC_W'(WIN_END));
        steal    = badline && in_win;
        win_last = badline && (raster_cycle == CYC_W'(WIN_END));
    end
endmodule

// File: rtl/bl_opseq.sv
module bl_opseq
    import bl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_start,
    input  op_desc_t op_in,
    input  logic     hold,
    output logic     cur_write
);
    op_desc_t          desc_q, cur_desc;
    logic [ICYC_W-1:0] cyc_q, cur_cyc;

    always_comb begin
        cur_desc  = op_start ? op_in : desc_q;
        cur_cyc   = op_start ? ICYC_W'(1) : cyc_q;
        cur_write = is_write_cycle(cur_desc, cur_cyc);
    end

    // Position inside the instruction advances only on completed cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '{cls: OPC_PLAIN, len: 3'd0, nwr: 2'd0};
            cyc_q  <= ICYC_MAX;
        end else begin
            desc_q <= cur_desc;
            cyc_q  <= hold ? cur_cyc : sat_inc(cur_cyc);
        end
    end
endmodule

// File: rtl/bl_stall.sv
module bl_stall #(
    parameter int FETCH_CNT = 40,
    parameter int LEAD      = 3
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    steal,
    input  logic                                    win_last,
    input  logic                                    cur_write,
    output logic                                    halt,
    output logic [$clog2(FETCH_CNT+LEAD+1)-1:0]     stall_len,
    output logic                                    stall_done
);
    localparam int CNT_W = $clog2(FETCH_CNT + LEAD + 1);
    localparam int MAX_STALL = FETCH_CNT + LEAD;

    logic             halted_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        halt     = steal && (halted_q || !cur_write);
        cnt_next = cnt_q + CNT_W'(halt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halted_q   <= 1'b0;
            cnt_q      <= '0;
            stall_len  <= '0;
            stall_done <= 1'b0;
        end else begin
            halted_q   <= halt;
            cnt_q      <= (steal && !win_last) ? cnt_next : '0;
            stall_done <= win_last;
            if (win_last)
                stall_len <= cnt_next;
        end
    end

    // R5: a hold persists while the bus stays stolen
    p_hold_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (steal && $past(halt) && $past(steal)) |-> halt);

    // R9: charged length never exceeds lead plus fetch cycles
    p_len_bound_r9: assert property (@(posedge clk) disable iff (rst)
        stall_done |-> (stall_len <= CNT_W'(MAX_STALL)));
endmodule

// File: rtl/badline_steal_arb.sv
module badline_steal_arb
    import bl_pkg::*;
#(
    parameter int LINE_CYCLES = 63,
    parameter int FETCH_FIRST = 15,
    parameter int FETCH_CNT   = 40,
    parameter int LEAD        = 3
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [$clog2(LINE_CYCLES)-1:0]        raster_cycle,
    input  logic                                  badline,
    input  logic                                  op_start,
    input  logic [1:0]                            op_class,
    input  logic [2:0]                            op_len,
    input  logic [1:0]                            op_nwr,
    output logic                                  ba_n,
    output logic                                  rdy,
    output logic [$clog2(FETCH_CNT+LEAD+1)-1:0]   stall_len,
    output logic                                  stall_done
);
    localparam int CYC_W     = $clog2(LINE_CYCLES);
    localparam int WIN_START = FETCH_FIRST - LEAD;

    logic     steal, win_last, cur_write, halt;
    op_desc_t op_in;

    always_comb begin
        op_in.cls = op_class_e'(op_class);
        op_in.len = op_len;
        op_in.nwr = op_nwr;
    end

    bl_window #(
        .LINE_CYCLES(LINE_CYCLES), .FETCH_FIRST(FETCH_FIRST),
        .FETCH_CNT(FETCH_CNT), .LEAD(LEAD)
    ) u_window (
        .raster_cycle(raster_cycle), .badline(badline),
        .steal(steal), .win_last(win_last)
    );

    bl_opseq u_opseq (
        .clk(clk), .rst(rst), .op_start(op_start), .op_in(op_in),
        .hold(halt), .cur_write(cur_write)
    );

    bl_stall #(.FETCH_CNT(FETCH_CNT), .LEAD(LEAD)) u_stall (
        .clk(clk), .rst(rst), .steal(steal), .win_last(win_last),
        .cur_write(cur_write), .halt(halt),
        .stall_len(stall_len), .stall_done(stall_done)
    );

    always_comb begin
        ba_n = !steal;
        rdy  = !halt;
    end

    // R10: processor is never held while the bus is free
    p_rdy_free_r10: assert property (@(posedge clk) disable iff (rst)
        ba_n |-> rdy);

    // R2: the warning opens on the lead-in cycle
    p_ba_open_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ba_n) |-> (raster_cycle == CYC_W'(WIN_START)));

    // R9: report strobe comes right after release
    p_done_after_release_r9: assert property (@(posedge clk) disable iff (rst)
        stall_done |-> (ba_n && $past(!ba_n)));
endmodule

// File: tb/tb_badline_steal_arb.sv
module tb_badline_steal_arb;
    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] raster_cycle;
    logic       badline, op_start;
    logic [1:0] op_class, op_nwr;
    logic [2:0] op_len;
    logic       ba_n, rdy, stall_done;
    logic [5:0] stall_len;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    bit finished = 0;

    always #2 clk = ~clk;

    badline_steal_arb dut (
        .clk(clk), .rst(rst), .raster_cycle(raster_cycle), .badline(badline),
        .op_start(op_start), .op_class(op_class), .op_len(op_len), .op_nwr(op_nwr),
        .ba_n(ba_n), .rdy(rdy), .stall_len(stall_len), .stall_done(stall_done)
    );

    task automatic check(string req, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Write positions per R6, R7, R8
    function automatic bit wr_pos(int cls, int len, int nwr, int c);
        if (cls == 0) return (c >= 3 && c <= 5);
        if (cls == 1) return (c >= 4 && c <= 5);
        return (c <= len) && (c > len - nwr);
    endfunction

    // Writes completed in the lead: consecutive writes from cycle k on
    function automatic int lead_writes(int cls, int len, int nwr, int k);
        int n = 0;
        for (int j = 0; j < 3; j++) begin
            if (wr_pos(cls, len, nwr, k + j)) n++;
            else break;
        end
        return n;
    endfunction

    // Monitor: pops expected charged length on each report strobe (R9)
    always @(negedge clk) begin
        if (!rst && stall_done) begin
            if (exp_q.size() == 0) check("R9 unexpected strobe", 1, 0);
            else check("R9 stall_len", int'(stall_len), exp_q.pop_front());
        end
    end

    // One raster line; instruction cycle k is placed on lead cycle 12.
    task automatic run_line(bit bl, int cls, int len, int nwr, int k);
        int nw = lead_writes(cls, len, nwr, k);
        if (bl) exp_q.push_back(43 - nw);
        for (int c = 0; c < 63; c++) begin
            @(posedge clk); #1;
            raster_cycle = 6'(c);
            badline      = bl;
            op_start     = (c == 12 - (k - 1));
            op_class     = 2'(cls);
            op_len       = 3'(len);
            op_nwr       = 2'(nwr);
            @(negedge clk);
            begin
                bit inw = bl && (c >= 12) && (c <= 54);
                bit exp_rdy;
                check(bl ? "R2 ba_n" : "R3 ba_n", int'(ba_n), inw ? 0 : 1);
                if (!inw) exp_rdy = 1;                 // R10, R3
                else if (c - 12 < nw) exp_rdy = 1;     // R4
                else exp_rdy = 0;                      // R5
                check(inw ? "R4/R5 rdy" : "R10 rdy", int'(rdy), int'(exp_rdy));
            end
        end
        @(posedge clk); #1;
        raster_cycle = 6'd0; badline = 1'b0; op_start = 1'b0;
        @(negedge clk);
        check("R9 queue drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; raster_cycle = '0; badline = 1'b0; op_start = 1'b0;
        op_class = 2'd2; op_len = 3'd2; op_nwr = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ba_n", int'(ba_n), 1);
        check("R1 rdy", int'(rdy), 1);
        check("R1 stall_len", int'(stall_len), 0);
        check("R1 stall_done", int'(stall_done), 0);
        @(posedge clk); #1; rst = 1'b0;

        run_line(0, 2, 3, 1, 1);   // R3: no fetch line
        run_line(1, 2, 4, 0, 1);   // R8: opcode fetch read -> 43
        run_line(1, 2, 5, 2, 4);   // R8: two trailing writes -> 41
        run_line(1, 2, 6, 3, 4);   // R8: three trailing writes -> 40
        run_line(1, 2, 3, 1, 3);   // R8: one trailing write -> 42
        run_line(1, 0, 7, 0, 3);   // R6: all three trap writes -> 40
        run_line(1, 0, 7, 0, 4);   // R6 -> 41
        run_line(1, 0, 7, 0, 5);   // R6 -> 42
        run_line(1, 0, 7, 0, 2);   // R6: read first -> 43
        run_line(1, 1, 6, 0, 4);   // R7 -> 41
        run_line(1, 1, 6, 0, 5);   // R7 -> 42
        run_line(1, 1, 6, 0, 3);   // R7: read first -> 43
        run_line(0, 0, 7, 0, 3);   // R3 again after traffic

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule